// File: doc/BRIEF.md
# Cascadable Column Data Loader with Drive-Level Encoding

This block is the digital core of a 160-column display segment driver. Row data arrives on an 8-bit bus, one byte per falling edge of a shift clock, so a full row takes 20 shift edges. Several identical loaders can share the bus through an active-low token chain. A loader captures bytes only while its token input is low. Once its last column is filled, it pulls its token output low, and that output feeds the next loader in the chain. A falling edge on the latch pulse copies the loaded row into an output latch, releases the token and rearms the column counter.

A single direction-select pin sets which of the two chain pins is the input and which is the output. The same pin reverses the order in which columns are filled. Each latched column is turned into a 2-bit drive-level code from its data bit and a frame-polarity input. An active-low blanking input forces every column to the lowest drive level.

The shift clock and the latch pulse are sampled as levels on the system clock `clk`, and their falling edges are detected internally. Reset is synchronous and active high.

Top module: `segcol_loader`

## Requirements
- R1: After reset, both chain outputs are high, the column counter is zero and the output latch holds all zeros.
- R2: On each falling edge of `shift_clk_i` while the block is enabled, one byte of `data_i` is stored into the next 8 columns. Rising edges store nothing.
- R3: When `dir_sel_i`=0, `chain_a_i` is the token input and `chain_b_o` is the token output (`chain_b_oe`=1, `chain_a_oe`=0). When `dir_sel_i`=1 the roles swap (`chain_a_oe`=1, `chain_b_oe`=0). Both chain outputs always carry the token value.
- R4: When `dir_sel_i`=0, bit b of byte k (k=0 first) goes to 0-based column 8k+7-b. Column 0 is therefore byte 0 bit 7, and column 159 is byte 19 bit 0.
- R5: When `dir_sel_i`=1, bit b of byte k goes to column 152-8k+b. Column 0 is therefore byte 19 bit 0, and column 159 is byte 0 bit 7.
- R6: The token output goes low one clock after the 20th byte is stored. A falling edge of `latch_i` drives it high again on the next clock and clears the column counter to zero.
- R7: While the selected token input is high, shift edges store nothing. Capture resumes at the next unfilled column when the token input returns low.
- R8: Shift edges that arrive after the 20th byte change neither the stored row nor the token.
- R9: The output latch loads the stored row on the clock after a falling edge of `latch_i` and changes at no other time.
- R10: When `blank_n_i`=1, each column code is 00 for data 1 with polarity 1, 01 for data 0 with polarity 1, 10 for data 0 with polarity 0, and 11 for data 1 with polarity 0. Column c occupies `seg_code_o[2c+1:2c]`.
- R11: When `blank_n_i`=0, every column code is 11, whatever the data and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Shift clock level; a byte is captured on its falling edge |
| latch_i | input | 1 | Latch pulse level; the row is latched on its falling edge |
| data_i | input | 8 | Display data byte |
| dir_sel_i | input | 1 | Chain direction and column order select |
| chain_a_i | input | 1 | Chain pin A, input value |
| chain_a_o | output | 1 | Chain pin A, output value (token, active low) |
| chain_a_oe | output | 1 | Chain pin A output enable |
| chain_b_i | input | 1 | Chain pin B, input value |
| chain_b_o | output | 1 | Chain pin B, output value (token, active low) |
| chain_b_oe | output | 1 | Chain pin B output enable |
| polarity_i | input | 1 | Frame polarity for drive-level selection |
| blank_n_i | input | 1 | Active-low forced blanking |
| seg_code_o | output | 320 | Per-column 2-bit drive-level codes |

## Verification
The assertions assume that `shift_clk_i` and `latch_i` each stay at a level for at least one system clock. They also assume that a latch falling edge never falls in the same cycle as a shift falling edge, and that `dir_sel_i` changes only between rows. The bench keeps to these assumptions. It drives every input on the falling edge of `clk`, holds each strobe level for at least one clock, and spaces the latch pulse away from shift edges. It changes the direction select only after a latch. A behavioural model, built on integer counters and bit arrays, predicts the chain pins and all 320 code bits every cycle. The model is compared against the design throughout the normal load, pause and resume, the reversed order, extra shift edges, and changes of polarity and blanking.

// File: rtl/segcol_pkg.sv
package segcol_pkg;

    localparam int SLOT_IDX_W = 8;

    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } drive_lvl_e;

    typedef struct packed {
        logic                  fire;
        logic                  rev;
        logic [SLOT_IDX_W-1:0] slot;
    } cap_evt_t;

    function automatic drive_lvl_e pick_level(input logic bit_v,
                                              input logic pol,
                                              input logic blank_n);
        drive_lvl_e lvl;
        if (!blank_n) begin
            lvl = LVL_V5;
        end else begin
            case ({bit_v, pol})
                2'b11:   lvl = LVL_V0;
                2'b01:   lvl = LVL_V2;
                2'b00:   lvl = LVL_V3;
                default: lvl = LVL_V5;
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/segcol_edge.sv
module segcol_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic fall_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign fall_o = lvl_q & ~lvl_i;

    // R2: a detected falling edge is never reported twice in a row
    p_single_fall_r2: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/segcol_token.sv
module segcol_token
    import segcol_pkg::*;
#(
    parameter int NUM_SLOTS = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sft_fall_i,
    input  logic     lat_fall_i,
    input  logic     sel_i,
    input  logic     pin_a_i,
    input  logic     pin_b_i,
    output logic     pin_a_o,
    output logic     pin_a_oe,
    output logic     pin_b_o,
    output logic     pin_b_oe,
    output logic     en_act_o,
    output cap_evt_t cap_o
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_SLOTS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             full_q;
    logic             en_act;
    logic             take;

    assign en_act = ~(sel_i ? pin_b_i : pin_a_i);
    assign take   = sft_fall_i & en_act & ~full_q & ~lat_fall_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (lat_fall_i) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) full_q <= 1'b1;
        end
    end

    assign pin_a_o  = ~full_q;
    assign pin_b_o  = ~full_q;
    assign pin_a_oe = sel_i;
    assign pin_b_oe = ~sel_i;
    assign en_act_o = en_act;

    always_comb begin
        cap_o      = '0;
        cap_o.fire = take;
        cap_o.rev  = sel_i;
        cap_o.slot = SLOT_IDX_W'(cnt_q);
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NUM_SLOTS));

    p_token_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        (take && cnt_q == LAST) |=> !pin_a_o && !pin_b_o);

    p_latch_release_r6: assert property (@(posedge clk) disable iff (rst)
        lat_fall_i |=> (cnt_q == '0) && pin_a_o && pin_b_o);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!en_act && !lat_fall_i) |=> $stable(cnt_q));

    p_extra_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (full_q && !lat_fall_i) |=> full_q && $stable(cnt_q));

endmodule

// File: rtl/segcol_rowbuf.sv
module segcol_rowbuf
    import segcol_pkg::*;
#(
    parameter int NUM_COLS = 160,
    parameter int BUS_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  cap_evt_t            cap_i,
    input  logic [BUS_W-1:0]    data_i,
    input  logic                lat_fall_i,
    output logic [NUM_COLS-1:0] lat_o
);
    localparam int NUM_SLOTS = NUM_COLS / BUS_W;

    logic [NUM_COLS-1:0] row_q;
    logic [NUM_COLS-1:0] lat_q;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam int SLOT_FWD = c / BUS_W;
        localparam int SLOT_REV = NUM_SLOTS - 1 - SLOT_FWD;
        localparam int POS      = c % BUS_W;
        logic hit;
        logic bit_v;

        assign hit = cap_i.fire &&
                     (cap_i.rev ? (cap_i.slot == SLOT_IDX_W'(SLOT_REV))
                                : (cap_i.slot == SLOT_IDX_W'(SLOT_FWD)));
        assign bit_v = cap_i.rev ? data_i[POS] : data_i[BUS_W-1-POS];

        always_ff @(posedge clk) begin
            if (rst)      row_q[c] <= 1'b0;
            else if (hit) row_q[c] <= bit_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             lat_q <= '0;
        else if (lat_fall_i) lat_q <= row_q;
    end

    assign lat_o = lat_q;

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !lat_fall_i |=> $stable(lat_o));

    p_row_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        !cap_i.fire |=> $stable(row_q));

endmodule

// File: rtl/segcol_encode.sv
module segcol_encode
    import segcol_pkg::*;
#(
    parameter int NUM_COLS = 160
) (
    input  logic [NUM_COLS-1:0]   lat_i,
    input  logic                  pol_i,
    input  logic                  blank_n_i,
    output logic [2*NUM_COLS-1:0] code_o
);
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_enc
        drive_lvl_e lvl;
        assign lvl            = pick_level(lat_i[c], pol_i, blank_n_i);
        assign code_o[2*c +: 2] = lvl;
    end
endmodule

// File: rtl/segcol_loader.sv
module segcol_loader
    import segcol_pkg::*;
#(
    parameter int NUM_COLS = 160,
    parameter int BUS_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_clk_i,
    input  logic                  latch_i,
    input  logic [BUS_W-1:0]      data_i,
    input  logic                  dir_sel_i,
    input  logic                  chain_a_i,
    output logic                  chain_a_o,
    output logic                  chain_a_oe,
    input  logic                  chain_b_i,
    output logic                  chain_b_o,
    output logic                  chain_b_oe,
    input  logic                  polarity_i,
    input  logic                  blank_n_i,
    output logic [2*NUM_COLS-1:0] seg_code_o
);
    localparam int NUM_SLOTS = NUM_COLS / BUS_W;

    logic                sft_fall;
    logic                lat_fall;
    logic                en_act;
    logic [BUS_W-1:0]    data_g;
    cap_evt_t            cap;
    logic [NUM_COLS-1:0] lat;

    segcol_edge u_sft_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (shift_clk_i),
        .fall_o (sft_fall)
    );

    segcol_edge u_lat_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (latch_i),
        .fall_o (lat_fall)
    );

    segcol_token #(.NUM_SLOTS(NUM_SLOTS)) u_token (
        .clk        (clk),
        .rst        (rst),
        .sft_fall_i (sft_fall),
        .lat_fall_i (lat_fall),
        .sel_i      (dir_sel_i),
        .pin_a_i    (chain_a_i),
        .pin_b_i    (chain_b_i),
        .pin_a_o    (chain_a_o),
        .pin_a_oe   (chain_a_oe),
        .pin_b_o    (chain_b_o),
        .pin_b_oe   (chain_b_oe),
        .en_act_o   (en_act),
        .cap_o      (cap)
    );

    // idle bus held low while the token is not held
    assign data_g = en_act ? data_i : '0;

    segcol_rowbuf #(.NUM_COLS(NUM_COLS), .BUS_W(BUS_W)) u_rowbuf (
        .clk        (clk),
        .rst        (rst),
        .cap_i      (cap),
        .data_i     (data_g),
        .lat_fall_i (lat_fall),
        .lat_o      (lat)
    );

    segcol_encode #(.NUM_COLS(NUM_COLS)) u_encode (
        .lat_i     (lat),
        .pol_i     (polarity_i),
        .blank_n_i (blank_n_i),
        .code_o    (seg_code_o)
    );

    always @(posedge clk) begin
        if (!rst && !blank_n_i) begin
            p_blank_all_r11: assert (&seg_code_o);
        end
        if (!rst && blank_n_i) begin
            p_code_col0_r10: assert (seg_code_o[1:0] == {~polarity_i, lat[0] ^ polarity_i});
        end
    end

    p_oe_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chain_a_oe, chain_b_oe}) && (chain_a_oe || chain_b_oe));

endmodule

// File: tb/tb_segcol_loader.sv
module tb_segcol_loader;
    localparam int NC = 160;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_clk_i = 1'b0, latch_i = 1'b0;
    logic [7:0] data_i = '0;
    logic dir_sel_i = 1'b0, chain_a_i = 1'b1, chain_b_i = 1'b1;
    logic polarity_i = 1'b0, blank_n_i = 1'b1;
    logic chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
    logic [2*NC-1:0] seg_code_o;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    segcol_loader dut (
        .clk(clk), .rst(rst), .shift_clk_i(shift_clk_i), .latch_i(latch_i),
        .data_i(data_i), .dir_sel_i(dir_sel_i),
        .chain_a_i(chain_a_i), .chain_a_o(chain_a_o), .chain_a_oe(chain_a_oe),
        .chain_b_i(chain_b_i), .chain_b_o(chain_b_o), .chain_b_oe(chain_b_oe),
        .polarity_i(polarity_i), .blank_n_i(blank_n_i), .seg_code_o(seg_code_o)
    );

    // behavioural reference model
    bit mrow [NC];
    bit mlat [NC];
    int mcnt;
    bit mfull, mscl_q, mlat_q;

    always @(posedge clk) begin
        bit sf, lf, en;
        sf = mscl_q && !shift_clk_i;
        lf = mlat_q && !latch_i;
        en = ((dir_sel_i ? chain_b_i : chain_a_i) == 1'b0);
        if (rst) begin
            foreach (mrow[i]) begin mrow[i] = 0; mlat[i] = 0; end
            mcnt = 0; mfull = 0; mscl_q = 0; mlat_q = 0;
        end else begin
            if (lf) begin
                foreach (mrow[i]) mlat[i] = mrow[i];
                mcnt = 0; mfull = 0;
            end else if (sf && en && mcnt < 20) begin
                for (int b = 0; b < 8; b++) begin
                    int col;
                    col = dir_sel_i ? (152 - 8*mcnt + b) : (8*mcnt + 7 - b);
                    mrow[col] = data_i[b];
                end
                mcnt++;
                if (mcnt == 20) mfull = 1;
            end
            mscl_q = shift_clk_i;
            mlat_q = latch_i;
        end
    end

    function automatic logic [1:0] ref_code(bit d, bit p, bit bn);
        if (!bn) return 2'b11;
        if (d && p) return 2'b00;
        if (!d && p) return 2'b01;
        if (!d && !p) return 2'b10;
        return 2'b11;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [2*NC-1:0] e;
        for (int c = 0; c < NC; c++) e[2*c +: 2] = ref_code(mlat[c], polarity_i, blank_n_i);
        chk("R6 chain pins", {28'd0, chain_a_o, chain_b_o, chain_a_oe, chain_b_oe},
            {28'd0, !mfull, !mfull, dir_sel_i, !dir_sel_i});
        total++;
        if (seg_code_o !== e) begin
            bad++;
            $display("FAIL R9 seg codes actual=%0h expected=%0h", seg_code_o, e);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) compare_model();
    endtask

    task automatic shift_byte(logic [7:0] v);
        data_i = v; shift_clk_i = 1'b1;
        step();
        shift_clk_i = 1'b0;
        step();
        step();
    endtask

    task automatic pulse_latch();
        latch_i = 1'b1;
        step();
        latch_i = 1'b0;
        step();
        step();
    endtask

    function automatic logic [7:0] pat(int set, int k);
        return 8'((k*37 + set*11 + 5) & 255);
    endfunction

    function automatic logic [1:0] col_code(int c);
        return seg_code_o[2*c +: 2];
    endfunction

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 chain outs", {30'd0, chain_a_o, chain_b_o}, 32'd3);
        chk("R1 latch zero code col0", {30'd0, col_code(0)}, 32'd2);
        chk("R1 latch zero code col159", {30'd0, col_code(159)}, 32'd2);
        // R3 direction of chain pins
        chk("R3 sel0 oe", {30'd0, chain_a_oe, chain_b_oe}, 32'd1);
        dir_sel_i = 1'b1; step();
        chk("R3 sel1 oe", {30'd0, chain_a_oe, chain_b_oe}, 32'd2);
        dir_sel_i = 1'b0; step();

        // R2 R4 R6 forward load
        chain_a_i = 1'b0;
        for (int k = 0; k < 19; k++) shift_byte(pat(0, k));
        chk("R6 token held after 19 bytes", {31'd0, chain_b_o}, 32'd1);
        shift_byte(pat(0, 19));
        chk("R6 token passed after 20 bytes", {31'd0, chain_b_o}, 32'd0);
        // R8 extra edges ignored
        for (int k = 0; k < 3; k++) shift_byte(8'hFF);
        chk("R8 token stays low", {31'd0, chain_b_o}, 32'd0);
        chk("R9 outputs unchanged before latch", {30'd0, col_code(0)}, 32'd2);
        polarity_i = 1'b1;
        pulse_latch();
        chk("R6 token released by latch", {31'd0, chain_b_o}, 32'd1);
        chk("R4 col0", {30'd0, col_code(0)},   {30'd0, ref_code(pat(0,0)[7], 1, 1)});
        chk("R4 col7", {30'd0, col_code(7)},   {30'd0, ref_code(pat(0,0)[0], 1, 1)});
        chk("R4 col85", {30'd0, col_code(85)}, {30'd0, ref_code(pat(0,10)[2], 1, 1)});
        chk("R4 col159", {30'd0, col_code(159)}, {30'd0, ref_code(pat(0,19)[0], 1, 1)});
        chk("R8 col159 not overwritten", {30'd0, col_code(159)}, {30'd0, ref_code(pat(0,19)[0], 1, 1)});

        // R7 pause and resume
        for (int k = 0; k < 10; k++) shift_byte(pat(1, k));
        chain_a_i = 1'b1;
        for (int k = 0; k < 4; k++) shift_byte(8'hAA);
        chk("R7 token not passed while paused", {31'd0, chain_b_o}, 32'd1);
        chain_a_i = 1'b0;
        for (int k = 10; k < 20; k++) shift_byte(pat(1, k));
        chk("R7 token passed after resume", {31'd0, chain_b_o}, 32'd0);
        pulse_latch();
        chk("R7 col80", {30'd0, col_code(80)}, {30'd0, ref_code(pat(1,10)[7], 1, 1)});
        chk("R7 col87", {30'd0, col_code(87)}, {30'd0, ref_code(pat(1,10)[0], 1, 1)});

        // R5 reversed order
        dir_sel_i = 1'b1; chain_a_i = 1'b1; chain_b_i = 1'b0;
        step();
        for (int k = 0; k < 20; k++) shift_byte(pat(2, k));
        chk("R5 token on pin A", {31'd0, chain_a_o}, 32'd0);
        pulse_latch();
        chk("R5 col0", {30'd0, col_code(0)},     {30'd0, ref_code(pat(2,19)[0], 1, 1)});
        chk("R5 col8", {30'd0, col_code(8)},     {30'd0, ref_code(pat(2,18)[0], 1, 1)});
        chk("R5 col159", {30'd0, col_code(159)}, {30'd0, ref_code(pat(2,0)[7], 1, 1)});

        // R10 code table, using a row of known bits
        for (int k = 0; k < 20; k++) shift_byte(8'h0F);
        pulse_latch();
        // reversed: col c = 152-8k+b, bits 0..3 set -> c%8 in 0..3 are ones
        chk("R10 d1 p1", {30'd0, col_code(0)}, 32'd0);
        chk("R10 d0 p1", {30'd0, col_code(4)}, 32'd1);
        polarity_i = 1'b0; step();
        chk("R10 d0 p0", {30'd0, col_code(4)}, 32'd2);
        chk("R10 d1 p0", {30'd0, col_code(0)}, 32'd3);
        // R11 blanking
        blank_n_i = 1'b0; step();
        chk("R11 col4 blank", {30'd0, col_code(4)}, 32'd3);
        chk("R11 all blank", {31'd0, &seg_code_o}, 32'd1);
        blank_n_i = 1'b1; polarity_i = 1'b1; step();
        chk("R11 release", {30'd0, col_code(4)}, 32'd1);
        repeat (4) step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule